// File: doc/BRIEF.md
# Register-write command stream decoder

The block turns a stream of 32-bit words into register writes. Words arrive over a valid/ready handshake and are read in pairs. The first word of a pair holds a compressed register index. The second word holds the value to write. The decoder expands the index into a byte address and then presents one write on a simple port made of an address, a data word and a strobe. The write port can stall a write by holding its busy input. While it does, the write stays on the port and the stream is held off.

The compressed index covers two address windows in one 9-bit space, and index bit 8 selects the window:
- Bit 8 clear: indices 0x000 to 0x0FF name the dword registers at byte addresses 0x400 to 0x7FF.
- Bit 8 set: indices 0x100 to 0x1FF name the registers at byte addresses 0x000 to 0x3FF.

An index word with any bit set above bit 8 is malformed. It is flagged, and its pair is dropped. An index word that is marked as the last word of the stream has no value word after it. It is flagged, and nothing is written.

The block also contains the reverse mapping, from byte address to compressed index, as a combinational port pair. Software models and checkers can use it to confirm that the two mappings are inverses of each other.

Top module: `regcmd_decoder`

## Requirements
- R1: Accepted words alternate between index and value. Each well-formed pair produces exactly one write, in stream order. The write's data equals the value word, and the strobe appears in the cycle after the value word is accepted.
- R2: An index with bit 8 clear (0x000 to 0x0FF) writes to byte address 0x400 + 4 × index, so 0x000 gives 0x400 and 0x0FF gives 0x7FC.
- R3: An index with bit 8 set (0x100 to 0x1FF) writes to byte address 4 × (index & 0xFF), so 0x100 gives 0x000 and 0x1FF gives 0x3FC.
- R4: Every address presented on the write port has its two low bits equal to 0.
- R5: An index word with any of bits 31:9 set raises errBadIndex for one cycle, in the cycle after that word is accepted. The value word that follows is consumed, and no write is made for the pair.
- R6: An index word accepted with inLast high raises errTruncated for one cycle in the next cycle and makes no write. The word after it is treated as a new index.
- R7: While wrStrobe and wrBusy are both high, inReady is low, and in the following cycle wrStrobe, wrAddr and wrData are unchanged.
- R8: The helper maps an aligned address of 0x400 or above to (address − 0x400) >> 2, and an address below 0x400 to (address >> 2) | 0x100. Expanding the result gives back the original address for every aligned address from 0x000 to 0x7FC.
- R9: After reset, inReady is high and wrStrobe, errBadIndex and errTruncated are low, and the first accepted word is taken as an index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 32 | Stream word (index or value) |
| inValid | input | 1 | Stream word valid |
| inLast | input | 1 | Marks the final word of the stream |
| inReady | output | 1 | Decoder can take a word this cycle |
| wrAddr | output | 11 | Expanded byte address of the write |
| wrData | output | 32 | Value to write |
| wrStrobe | output | 1 | Write request, held until wrBusy is low |
| wrBusy | input | 1 | Write port stalls the pending write |
| errBadIndex | output | 1 | One-cycle pulse for a malformed index |
| errTruncated | output | 1 | One-cycle pulse for an index with no value |
| mapAddr | input | 11 | Byte address for the reverse mapping |
| mapIndex | output | 9 | Compressed index of mapAddr |

## Verification
The bench runs directed pairs at the four edge indices 0x000, 0x0FF, 0x100 and 0x1FF. These separate the two windows and expose any slip in the offset or the window-select bit.

A seeded random stream follows. It mixes well-formed pairs with malformed and truncated index words, with random stalls on the write port. This shows whether the phase stays aligned after a pair is dropped, and whether held writes keep their address and data.

Finally, an exhaustive sweep of all 512 aligned addresses through the reverse helper, compared against a bench model, checks that compressing an address and then expanding it returns the original address.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;

  localparam int IDX_W  = 9;            // compressed index width
  localparam int WIN_W  = IDX_W - 1;    // dword slots per window, log2
  localparam int ADDR_W = WIN_W + 3;    // byte address width
  localparam logic [ADDR_W-1:0] UPPER_BASE = ADDR_W'(1) << (WIN_W + 2);

  typedef logic [IDX_W-1:0]  regIdx_t;
  typedef logic [ADDR_W-1:0] regAddr_t;

  typedef enum logic {PH_INDEX, PH_VALUE} phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadIdx;
    logic loadWrite;
  } dpStrobe_t;

  // window bit set selects the lower address window
  function automatic regAddr_t expandIndex(regIdx_t idx);
    regAddr_t slot;
    slot = {1'b0, idx[WIN_W-1:0], 2'b00};
    if (idx[IDX_W-1]) return slot;
    return UPPER_BASE | slot;
  endfunction

  function automatic regIdx_t compressAddr(regAddr_t addr);
    if (addr[ADDR_W-1]) return {1'b0, addr[ADDR_W-2:2]};
    return {1'b1, addr[ADDR_W-2:2]};
  endfunction

endpackage

// File: rtl/regcmd_addr2idx.sv
module regcmd_addr2idx
  import regcmd_pkg::*;
(
  input  logic [ADDR_W-1:0] mapAddr,
  output logic [IDX_W-1:0]  mapIndex
);

  always_comb begin
    mapIndex = compressAddr(mapAddr);
    // p_roundtrip_r8: expanding the index returns the aligned address
    p_roundtrip_r8: assert (expandIndex(mapIndex) == {mapAddr[ADDR_W-1:2], 2'b00});
  end

endmodule

// File: rtl/regcmd_ctrl.sv
module regcmd_ctrl
  import regcmd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inLast,
  input  logic      idxOk,
  input  logic      wrBusy,
  output logic      inReady,
  output logic      wrStrobe,
  output logic      errBadIndex,
  output logic      errTruncated,
  output dpStrobe_t dp
);

  phase_t phase;
  logic   dropPair;
  logic   accept;
  logic   stalled;

  assign stalled = wrStrobe && wrBusy;
  assign inReady = !stalled;
  assign accept  = inValid && inReady;

  always_comb begin
    dp.loadIdx   = accept && (phase == PH_INDEX);
    dp.loadWrite = accept && (phase == PH_VALUE) && !dropPair;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase        <= PH_INDEX;
      dropPair     <= 1'b0;
      wrStrobe     <= 1'b0;
      errBadIndex  <= 1'b0;
      errTruncated <= 1'b0;
    end else begin
      errBadIndex  <= 1'b0;
      errTruncated <= 1'b0;
      if (dp.loadWrite)  wrStrobe <= 1'b1;
      else if (!wrBusy)  wrStrobe <= 1'b0;
      if (accept) begin
        if (phase == PH_INDEX) begin
          errBadIndex <= !idxOk;
          if (inLast) begin
            errTruncated <= 1'b1;
          end else begin
            phase    <= PH_VALUE;
            dropPair <= !idxOk;
          end
        end else begin
          phase    <= PH_INDEX;
          dropPair <= 1'b0;
        end
      end
    end
  end

  // R7: a stalled write stays on the port
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe && wrBusy |=> wrStrobe);

  // R5: a dropped pair produces no write
  p_bad_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    accept && (phase == PH_VALUE) && dropPair |=> !wrStrobe);

  // R6: a truncated index leaves the decoder expecting an index
  p_trunc_phase_r6: assert property (@(posedge clk) disable iff (!rstN)
    errTruncated |-> phase == PH_INDEX);

endmodule

// File: rtl/regcmd_dpath.sv
module regcmd_dpath
  import regcmd_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  dpStrobe_t         dp,
  output logic              idxOk,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);

  regIdx_t idxReg;

  assign idxOk = ~|inData[DATA_W-1:IDX_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg <= '0;
      wrAddr <= '0;
      wrData <= '0;
    end else begin
      if (dp.loadIdx) idxReg <= inData[IDX_W-1:0];
      if (dp.loadWrite) begin
        wrAddr <= expandIndex(idxReg);
        wrData <= inData;
      end
    end
  end

  p_upper_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    dp.loadWrite && !idxReg[IDX_W-1] |=> wrAddr[ADDR_W-1]);

  p_lower_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    dp.loadWrite && idxReg[IDX_W-1] |=> !wrAddr[ADDR_W-1]);

endmodule

// File: rtl/regcmd_decoder.sv
module regcmd_decoder
  import regcmd_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrStrobe,
  input  logic              wrBusy,
  output logic              errBadIndex,
  output logic              errTruncated,
  input  logic [ADDR_W-1:0] mapAddr,
  output logic [IDX_W-1:0]  mapIndex
);

  dpStrobe_t dp;
  logic      idxOk;

  regcmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .idxOk(idxOk), .wrBusy(wrBusy), .inReady(inReady), .wrStrobe(wrStrobe),
    .errBadIndex(errBadIndex), .errTruncated(errTruncated), .dp(dp)
  );

  regcmd_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .inData(inData), .dp(dp),
    .idxOk(idxOk), .wrAddr(wrAddr), .wrData(wrData)
  );

  regcmd_addr2idx u_map (.mapAddr(mapAddr), .mapIndex(mapIndex));

  p_aligned_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> wrAddr[1:0] == 2'b00);

  p_hold_payload_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe && wrBusy |=> $stable(wrAddr) && $stable(wrData));

endmodule

// File: tb/regcmd_decoder_tb.sv
module regcmd_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] inData = '0;
  logic        inValid = 1'b0;
  logic        inLast = 1'b0;
  logic        inReady;
  logic [10:0] wrAddr;
  logic [31:0] wrData;
  logic        wrStrobe;
  logic        wrBusy = 1'b0;
  logic        errBadIndex;
  logic        errTruncated;
  logic [10:0] mapAddr = '0;
  logic [8:0]  mapIndex;

  int checks = 0;
  int errors = 0;
  int expBad = 0, expTrunc = 0, seenBad = 0, seenTrunc = 0, stallSeen = 0;
  bit busyEn = 1'b0;
  bit prevStall = 1'b0;
  logic [10:0] prevAddr;
  logic [31:0] prevData;
  logic [10:0] expAddrQ[$];
  logic [31:0] expDataQ[$];
  string       expTagQ[$];

  always #5 clk = ~clk;

  regcmd_decoder u_dut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .wrAddr(wrAddr), .wrData(wrData), .wrStrobe(wrStrobe),
    .wrBusy(wrBusy), .errBadIndex(errBadIndex), .errTruncated(errTruncated),
    .mapAddr(mapAddr), .mapIndex(mapIndex)
  );

  function automatic logic [10:0] refExpand(logic [8:0] idx);
    if (idx >= 9'h100) return 11'((idx - 9'h100) * 4);
    return 11'(11'h400 + idx * 4);
  endfunction

  function automatic logic [8:0] refCompress(logic [10:0] a);
    if (a >= 11'h400) return 9'((a - 11'h400) / 4);
    return 9'(a / 4 + 11'h100);
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic sendWord(logic [31:0] w, bit last);
    bit r;
    @(negedge clk);
    inData = w; inValid = 1'b1; inLast = last;
    forever begin
      #2; r = inReady;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic sendPair(logic [8:0] idx, logic [31:0] val, string tag);
    expAddrQ.push_back(refExpand(idx));
    expDataQ.push_back(val);
    expTagQ.push_back(tag);
    sendWord({23'd0, idx}, 1'b0);
    sendWord(val, 1'b0);
  endtask

  always @(negedge clk) wrBusy <= busyEn ? ($urandom % 3 == 0) : 1'b0;

  // monitor, sampled mid-cycle
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      if (errBadIndex)  seenBad++;
      if (errTruncated) seenTrunc++;
      if (prevStall) begin
        check(wrStrobe && wrAddr == prevAddr && wrData == prevData,
              "R7 held write", {21'd0, wrAddr}, {21'd0, prevAddr});
      end
      prevStall = wrStrobe && wrBusy;
      prevAddr = wrAddr; prevData = wrData;
      if (wrStrobe && wrBusy) begin
        stallSeen++;
        check(!inReady, "R7 ready low", {31'd0, inReady}, 32'd0);
      end
      if (wrStrobe && !wrBusy) begin
        check(wrAddr[1:0] == 2'b00, "R4 alignment", {30'd0, wrAddr[1:0]}, 32'd0);
        if (expAddrQ.size() == 0) begin
          check(1'b0, "R1 unexpected write", {21'd0, wrAddr}, 32'd0);
        end else begin
          string t;
          logic [10:0] ea;
          logic [31:0] ed;
          t = expTagQ.pop_front(); ea = expAddrQ.pop_front(); ed = expDataQ.pop_front();
          check(wrAddr == ea, {t, " address"}, {21'd0, wrAddr}, {21'd0, ea});
          check(wrData == ed, "R1 data", wrData, ed);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #2;
    // R9 reset state
    check(inReady && !wrStrobe && !errBadIndex && !errTruncated, "R9 reset state",
          {28'd0, inReady, wrStrobe, errBadIndex, errTruncated}, 32'h8);

    // R8 exhaustive reverse mapping and round trip
    for (int a = 0; a < 2048; a += 4) begin
      mapAddr = 11'(a);
      #1;
      check(mapIndex == refCompress(11'(a)), "R8 compress", {23'd0, mapIndex},
            {23'd0, refCompress(11'(a))});
      check(refExpand(mapIndex) == 11'(a), "R8 round trip", {21'd0, refExpand(mapIndex)}, a);
    end

    // directed window edges
    sendPair(9'h000, 32'hA000_0001, "R2 low edge");
    sendPair(9'h0FF, 32'hA000_0002, "R2 high edge");
    sendPair(9'h100, 32'hA000_0003, "R3 low edge");
    sendPair(9'h1FF, 32'hA000_0004, "R3 high edge");

    // R5 malformed index then a good pair
    expBad++;
    sendWord(32'h0000_0200, 1'b0);
    sendWord(32'hDEAD_BEEF, 1'b0);
    sendPair(9'h012, 32'h1234_5678, "R5 realign");

    // R6 truncated index, next word is an index
    expTrunc++;
    sendWord(32'h0000_0045, 1'b1);
    sendPair(9'h145, 32'h8765_4321, "R6 realign");

    // random traffic with stalls
    busyEn = 1'b1;
    for (int n = 0; n < 300; n++) begin
      int r;
      r = $urandom % 16;
      if (r == 0) begin
        expBad++;
        sendWord($urandom | 32'h0000_0200, 1'b0);
        sendWord($urandom, 1'b0);
      end else if (r == 1) begin
        expTrunc++;
        sendWord({23'd0, 9'($urandom)}, 1'b1);
      end else begin
        logic [8:0] ix;
        ix = 9'($urandom);
        sendPair(ix, $urandom, ix[8] ? "R3 random" : "R2 random");
      end
    end
    busyEn = 1'b0;
    repeat (10) @(negedge clk);
    #3;

    check(expAddrQ.size() == 0, "R1 all writes issued", expAddrQ.size(), 0);
    check(seenBad == expBad, "R5 bad index pulses", seenBad, expBad);
    check(seenTrunc == expTrunc, "R6 truncation pulses", seenTrunc, expTrunc);
    check(stallSeen > 0, "R7 stalls exercised", stallSeen, 1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule